// File: doc/BRIEF.md
# Prioritized Interrupt Acceptance Unit

This block sits next to one processor core and collects the interrupt requests aimed at it. Each request carries an 8-bit vector, a 3-bit delivery mode and a level/edge trigger flag. Regular requests (fixed and lowest-priority) are queued as bits in a 256-entry request bitmap. Alongside it sit a 256-entry in-service bitmap and a 256-entry trigger bitmap. The special modes (system management, non-maskable, init, startup and external) are each held as a single pending flag with the vector it arrived with.

The unit raises `deliverable_o` whenever something may be taken by the core. A regular interrupt is admitted only when its priority class (vector bits 7:4) beats the task priority class and the vector outranks the one already in service. When the core pulses `ack_i`, the unit picks the winner by a fixed order and reports it one cycle later. It then moves a regular vector from pending to in service. A pulse on `eoi_i` retires the highest in-service vector.

Top module: `intr_accept`

## Requirements
- R1: A request with mode 0 (fixed) or mode 1 (lowest-priority) sets the request bit of its vector. A request for a vector whose request bit is already set leaves all bitmaps unchanged.
- R2: When a request bit goes from clear to set, the trigger bit of that vector takes the request's level flag (1 level, 0 edge). When that vector is acknowledged, `ack_level_o` reports the trigger bit.
- R3: Modes 2 (system management), 4 (non-maskable), 5 (init) and 6 (startup) each set their own pending flag and capture the vector, but only while that flag is clear. Any of these flags makes `deliverable_o` high whatever the value of `int_en_i`.
- R4: Mode 7 (external) is captured in the same way as R3. It counts toward `deliverable_o` and acknowledge only while `int_en_i` is high.
- R5: A request with mode 3 is discarded with no effect on any state.
- R6: A regular interrupt is deliverable only when `int_en_i` is high, `irr_top_o` > `isr_top_o`, and `irr_top_o[7:4]` > task priority bits 7:4.
- R7: When `ack_i` is high and `deliverable_o` is high, the cycle after shows `ack_valid_o`=1. The winner is taken in this order: system management, non-maskable, init, startup, external, regular. `ack_kind_o` encodes the winner as 5, 4, 3, 2, 1, 0 respectively. Only the winner's flag is cleared. An `ack_i` while not deliverable produces no `ack_valid_o`.
- R8: Acknowledging a regular interrupt clears its request bit and sets its in-service bit. From the next cycle `isr_top_o` equals that vector and `irr_top_o` shows the next highest request.
- R9: An `eoi_i` pulse clears the in-service bit of `isr_top_o`. From the next cycle `isr_top_o` shows the next highest in-service vector.
- R10: A task priority write keeps only bits 7:0 of `tpr_wdata_i`, visible on `tpr_o` the next cycle.
- R11: `irr_top_o` and `isr_top_o` are the highest set bit index of their bitmap, and 0 when the bitmap is empty.
- R12: After reset, all bitmaps, flags, the task priority and the acknowledge outputs are 0, and `deliverable_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_vector_i | input | 8 | Request vector |
| req_mode_i | input | 3 | Delivery mode of the request |
| req_level_i | input | 1 | 1 level-triggered, 0 edge-triggered |
| int_en_i | input | 1 | Core interrupt enable |
| tpr_we_i | input | 1 | Task priority write strobe |
| tpr_wdata_i | input | 32 | Task priority write data |
| eoi_i | input | 1 | End-of-interrupt strobe |
| ack_i | input | 1 | Core acknowledge strobe |
| deliverable_o | output | 1 | Something can be acknowledged |
| ack_valid_o | output | 1 | Acknowledge result valid |
| ack_vector_o | output | 8 | Acknowledged vector |
| ack_kind_o | output | 3 | Acknowledged interrupt class |
| ack_level_o | output | 1 | Trigger bit of acknowledged regular vector |
| tpr_o | output | 8 | Task priority |
| irr_top_o | output | 8 | Highest pending regular vector |
| isr_top_o | output | 8 | Highest in-service vector |

## Verification
The bench sets up a request whose class equals the task priority class. A design that compared with "greater or equal" would deliver it too early. It repeats a request for an already-pending vector with the opposite trigger flag; a design that rewrote the trigger bit would report the wrong level on acknowledge. It also repeats a special request while that flag is pending, and a design that relatched would hand back the second vector. With all five special flags and a regular request pending at once, acknowledges must come out in the fixed order. The external and regular ones must be held back while interrupts are disabled, and a wrong order or a mask leak shows as a mismatched vector or kind. Reserved-mode requests, an acknowledge with nothing deliverable, and a lower vector hidden behind a higher one in service expose designs that queue, answer or nest where they must not.

// File: rtl/intr_pkg.sv
package intr_pkg;
  localparam int NSPEC    = 5;
  localparam int SLOT_EXT = 4;

  typedef enum logic [2:0] {
    DM_FIXED   = 3'd0,
    DM_LOWEST  = 3'd1,
    DM_SMI     = 3'd2,
    DM_RSVD    = 3'd3,
    DM_NMI     = 3'd4,
    DM_INIT    = 3'd5,
    DM_STARTUP = 3'd6,
    DM_EXT     = 3'd7
  } dmode_e;

  typedef enum logic [2:0] {
    IK_REGULAR = 3'd0,
    IK_EXT     = 3'd1,
    IK_STARTUP = 3'd2,
    IK_INIT    = 3'd3,
    IK_NMI     = 3'd4,
    IK_SMI     = 3'd5
  } ikind_e;

  // slot index doubles as service priority: 0 is served first
  function automatic dmode_e slot_mode(int s);
    case (s)
      0:       return DM_SMI;
      1:       return DM_NMI;
      2:       return DM_INIT;
      3:       return DM_STARTUP;
      default: return DM_EXT;
    endcase
  endfunction

  function automatic ikind_e slot_kind(int s);
    case (s)
      0:       return IK_SMI;
      1:       return IK_NMI;
      2:       return IK_INIT;
      3:       return IK_STARTUP;
      default: return IK_EXT;
    endcase
  endfunction
endpackage

// File: rtl/intr_prio_enc.sv
module intr_prio_enc #(
  parameter int N = 256,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] bits_i,
  output logic [W-1:0] idx_o,
  output logic         any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (bits_i[i]) idx_o = W'(i);
    end
  end
  assign any_o = |bits_i;
endmodule

// File: rtl/intr_vec_store.sv
module intr_vec_store #(
  parameter int VEC_W = 8,
  localparam int NVEC = 1 << VEC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic [VEC_W-1:0] set_vec_i,
  input  logic             set_level_i,
  input  logic             take_i,
  input  logic [VEC_W-1:0] take_vec_i,
  input  logic             eoi_i,
  input  logic [VEC_W-1:0] eoi_vec_i,
  output logic [NVEC-1:0]  irr_o,
  output logic [NVEC-1:0]  isr_o,
  output logic [NVEC-1:0]  tmr_o
);
  logic [NVEC-1:0] irr_q, isr_q, tmr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irr_q <= '0;
      isr_q <= '0;
      tmr_q <= '0;
    end else begin
      // a duplicate request leaves trigger state alone
      if (set_i && !irr_q[set_vec_i]) begin
        irr_q[set_vec_i] <= 1'b1;
        tmr_q[set_vec_i] <= set_level_i;
      end
      if (eoi_i) isr_q[eoi_vec_i] <= 1'b0;
      if (take_i) begin
        irr_q[take_vec_i] <= 1'b0;
        isr_q[take_vec_i] <= 1'b1;
      end
    end
  end

  assign irr_o = irr_q;
  assign isr_o = isr_q;
  assign tmr_o = tmr_q;
endmodule

// File: rtl/intr_special_flags.sv
module intr_special_flags
  import intr_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_valid_i,
  input  logic [2:0]                  req_mode_i,
  input  logic [VEC_W-1:0]            req_vector_i,
  input  logic [NSPEC-1:0]            clr_i,
  output logic [NSPEC-1:0]            pend_o,
  output logic [NSPEC-1:0][VEC_W-1:0] vec_o
);
  for (genvar g = 0; g < NSPEC; g++) begin : g_slot
    localparam dmode_e SLOT_M = slot_mode(g);
    logic             pend_q;
    logic [VEC_W-1:0] vec_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q <= 1'b0;
        vec_q  <= '0;
      end else if (clr_i[g]) begin
        pend_q <= 1'b0;
      end else if (req_valid_i && req_mode_i == SLOT_M && !pend_q) begin
        pend_q <= 1'b1;
        vec_q  <= req_vector_i;
      end
    end

    assign pend_o[g] = pend_q;
    assign vec_o[g]  = vec_q;
  end
endmodule

// File: rtl/intr_arbiter.sv
module intr_arbiter
  import intr_pkg::*;
#(
  parameter int VEC_W   = 8,
  parameter int CLASS_W = 4
) (
  input  logic [NSPEC-1:0]            pend_i,
  input  logic [NSPEC-1:0][VEC_W-1:0] spec_vec_i,
  input  logic                        int_en_i,
  input  logic                        irr_any_i,
  input  logic [VEC_W-1:0]            irr_top_i,
  input  logic [VEC_W-1:0]            isr_top_i,
  input  logic [VEC_W-1:0]            tpr_i,
  output logic                        deliv_o,
  output logic                        take_reg_o,
  output logic [NSPEC-1:0]            clr_o,
  output ikind_e                      kind_o,
  output logic [VEC_W-1:0]            vec_o
);
  logic reg_ok;
  logic found;

  assign reg_ok = int_en_i && irr_any_i && (irr_top_i > isr_top_i) &&
                  (irr_top_i[VEC_W-1 -: CLASS_W] > tpr_i[VEC_W-1 -: CLASS_W]);

  always_comb begin
    found      = 1'b0;
    take_reg_o = 1'b0;
    clr_o      = '0;
    kind_o     = IK_REGULAR;
    vec_o      = irr_top_i;
    for (int s = 0; s < NSPEC; s++) begin
      if (!found && pend_i[s] && (s != SLOT_EXT || int_en_i)) begin
        found    = 1'b1;
        clr_o[s] = 1'b1;
        kind_o   = slot_kind(s);
        vec_o    = spec_vec_i[s];
      end
    end
    if (!found && reg_ok) begin
      found      = 1'b1;
      take_reg_o = 1'b1;
    end
    deliv_o = found;
  end
endmodule

// File: rtl/intr_accept.sv
module intr_accept
  import intr_pkg::*;
#(
  parameter int VEC_W   = 8,
  parameter int CLASS_W = 4,
  parameter int TPR_DW  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [VEC_W-1:0]  req_vector_i,
  input  logic [2:0]        req_mode_i,
  input  logic              req_level_i,
  input  logic              int_en_i,
  input  logic              tpr_we_i,
  input  logic [TPR_DW-1:0] tpr_wdata_i,
  input  logic              eoi_i,
  input  logic              ack_i,
  output logic              deliverable_o,
  output logic              ack_valid_o,
  output logic [VEC_W-1:0]  ack_vector_o,
  output logic [2:0]        ack_kind_o,
  output logic              ack_level_o,
  output logic [VEC_W-1:0]  tpr_o,
  output logic [VEC_W-1:0]  irr_top_o,
  output logic [VEC_W-1:0]  isr_top_o
);
  localparam int NVEC = 1 << VEC_W;

  logic [NVEC-1:0]            irr, isr, tmr;
  logic [NSPEC-1:0]           pend, clr_sel, clr;
  logic [NSPEC-1:0][VEC_W-1:0] spec_vec;
  logic [VEC_W-1:0]           irr_top, isr_top, sel_vec, tpr_q;
  logic                       irr_any, isr_any, deliv, take_sel, take;
  logic                       reg_req;
  ikind_e                     sel_kind;

  assign reg_req = req_valid_i &&
                   (req_mode_i == DM_FIXED || req_mode_i == DM_LOWEST);
  assign take    = ack_i && take_sel;
  assign clr     = ack_i ? clr_sel : '0;

  intr_vec_store #(.VEC_W(VEC_W)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_i       (reg_req),
    .set_vec_i   (req_vector_i),
    .set_level_i (req_level_i),
    .take_i      (take),
    .take_vec_i  (irr_top),
    .eoi_i       (eoi_i),
    .eoi_vec_i   (isr_top),
    .irr_o       (irr),
    .isr_o       (isr),
    .tmr_o       (tmr)
  );

  intr_special_flags #(.VEC_W(VEC_W)) u_flags (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_mode_i   (req_mode_i),
    .req_vector_i (req_vector_i),
    .clr_i        (clr),
    .pend_o       (pend),
    .vec_o        (spec_vec)
  );

  intr_prio_enc #(.N(NVEC)) u_irr_enc (
    .bits_i (irr),
    .idx_o  (irr_top),
    .any_o  (irr_any)
  );

  intr_prio_enc #(.N(NVEC)) u_isr_enc (
    .bits_i (isr),
    .idx_o  (isr_top),
    .any_o  (isr_any)
  );

  intr_arbiter #(.VEC_W(VEC_W), .CLASS_W(CLASS_W)) u_arb (
    .pend_i     (pend),
    .spec_vec_i (spec_vec),
    .int_en_i   (int_en_i),
    .irr_any_i  (irr_any),
    .irr_top_i  (irr_top),
    .isr_top_i  (isr_top),
    .tpr_i      (tpr_q),
    .deliv_o    (deliv),
    .take_reg_o (take_sel),
    .clr_o      (clr_sel),
    .kind_o     (sel_kind),
    .vec_o      (sel_vec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tpr_q <= '0;
    else if (tpr_we_i) tpr_q <= tpr_wdata_i[VEC_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_valid_o  <= 1'b0;
      ack_vector_o <= '0;
      ack_kind_o   <= '0;
      ack_level_o  <= 1'b0;
    end else begin
      ack_valid_o <= ack_i && deliv;
      if (ack_i && deliv) begin
        ack_vector_o <= sel_vec;
        ack_kind_o   <= sel_kind;
        ack_level_o  <= take_sel && tmr[sel_vec];
      end
    end
  end

  assign deliverable_o = deliv;
  assign tpr_o         = tpr_q;
  assign irr_top_o     = irr_top;
  assign isr_top_o     = isr_any ? isr_top : '0;
endmodule

// File: rtl/intr_accept_chk.sv
module intr_accept_chk #(
  parameter int VEC_W  = 8,
  parameter int TPR_DW = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [VEC_W-1:0]  req_vector_i,
  input logic [2:0]        req_mode_i,
  input logic              req_level_i,
  input logic              int_en_i,
  input logic              tpr_we_i,
  input logic [TPR_DW-1:0] tpr_wdata_i,
  input logic              eoi_i,
  input logic              ack_i,
  input logic              deliverable_o,
  input logic              ack_valid_o,
  input logic [VEC_W-1:0]  ack_vector_o,
  input logic [2:0]        ack_kind_o,
  input logic              ack_level_o,
  input logic [VEC_W-1:0]  tpr_o,
  input logic [VEC_W-1:0]  irr_top_o,
  input logic [VEC_W-1:0]  isr_top_o
);
  p_rsvd_drop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_mode_i == 3'd3 && !ack_i && !eoi_i
    |=> $stable(irr_top_o) && $stable(isr_top_o));

  p_unmask_deliv_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_mode_i == 3'd4 && !ack_i |=> deliverable_o);

  p_ack_source_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_valid_o |-> $past(ack_i) && $past(deliverable_o));

  p_take_in_service_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_valid_o && ack_kind_o == 3'd0 && !$past(eoi_i)
    |-> isr_top_o == ack_vector_o);

  p_eoi_lowers_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_i && !ack_i && isr_top_o != '0 |=> isr_top_o < $past(isr_top_o));

  p_masked_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_valid_o && (ack_kind_o == 3'd0 || ack_kind_o == 3'd1) |-> $past(int_en_i));

  p_tpr_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tpr_we_i |=> tpr_o == $past(tpr_wdata_i[VEC_W-1:0]));
endmodule

bind intr_accept intr_accept_chk #(.VEC_W(VEC_W), .TPR_DW(TPR_DW)) u_chk (.*);

// File: tb/intr_accept_tb.sv
`timescale 1ns/1ps
module intr_accept_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [7:0] req_vector = '0;
  logic [2:0] req_mode = '0;
  logic       req_level = 1'b0;
  logic       int_en = 1'b0;
  logic       tpr_we = 1'b0;
  logic [31:0] tpr_wdata = '0;
  logic       eoi = 1'b0;
  logic       ack = 1'b0;
  logic       deliverable, ack_valid, ack_level;
  logic [7:0] ack_vector, tpr, irr_top, isr_top;
  logic [2:0] ack_kind;

  int n_tests = 0;
  int n_fail  = 0;

  typedef struct packed {
    logic [7:0] vec;
    logic [2:0] kind;
    logic       lvl;
  } exp_t;
  exp_t sb_q[$];

  always #2 clk = ~clk;

  intr_accept u_dut (
    .clk_i (clk), .rst_ni (rst_n),
    .req_valid_i (req_valid), .req_vector_i (req_vector),
    .req_mode_i (req_mode), .req_level_i (req_level),
    .int_en_i (int_en), .tpr_we_i (tpr_we), .tpr_wdata_i (tpr_wdata),
    .eoi_i (eoi), .ack_i (ack),
    .deliverable_o (deliverable), .ack_valid_o (ack_valid),
    .ack_vector_o (ack_vector), .ack_kind_o (ack_kind),
    .ack_level_o (ack_level), .tpr_o (tpr),
    .irr_top_o (irr_top), .isr_top_o (isr_top)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(logic [2:0] m, logic [7:0] v, logic l);
    @(negedge clk);
    req_valid = 1'b1; req_mode = m; req_vector = v; req_level = l;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wr_tpr(logic [31:0] d);
    @(negedge clk);
    tpr_we = 1'b1; tpr_wdata = d;
    @(negedge clk);
    tpr_we = 1'b0;
  endtask

  task automatic pulse_eoi();
    @(negedge clk);
    eoi = 1'b1;
    @(negedge clk);
    eoi = 1'b0;
  endtask

  // driver: pushes the expected result, then pulses the acknowledge
  task automatic do_ack(bit expect_one, logic [7:0] v, logic [2:0] k, logic l);
    @(negedge clk);
    ack = 1'b1;
    if (expect_one) sb_q.push_back('{vec: v, kind: k, lvl: l});
    @(negedge clk);
    ack = 1'b0;
    if (!expect_one) chk("R7 idle ack no result", ack_valid, 0);
  endtask

  // monitor: compares every produced result against the scoreboard
  always @(negedge clk) begin
    if (rst_n && ack_valid) begin
      n_tests++;
      if (sb_q.size() == 0) begin
        n_fail++;
        $display("FAIL R7 unexpected ack actual=%0h expected=none", ack_vector);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        if (ack_vector !== e.vec || ack_kind !== e.kind || ack_level !== e.lvl) begin
          n_fail++;
          $display("FAIL R7/R2 ack actual=%0h/%0d/%0b expected=%0h/%0d/%0b",
                   ack_vector, ack_kind, ack_level, e.vec, e.kind, e.lvl);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 deliverable", deliverable, 0);
    chk("R12 ack_valid", ack_valid, 0);
    chk("R12 irr_top", irr_top, 0);
    chk("R12 isr_top", isr_top, 0);
    chk("R12 tpr", tpr, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 only the low byte is kept
    wr_tpr(32'hABCD_1230);
    chk("R10 tpr low byte", tpr, 8'h30);

    // R1 fixed request queues while masked
    send(3'd0, 8'h35, 1'b0);
    chk("R1 irr_top", irr_top, 8'h35);
    chk("R6 masked", deliverable, 0);
    @(negedge clk); int_en = 1'b1;
    @(negedge clk);
    chk("R6 equal class blocked", deliverable, 0);
    wr_tpr(32'h20);
    chk("R6 class above tpr", deliverable, 1);

    // R1/R2 level request then duplicate edge request
    send(3'd1, 8'h50, 1'b1);
    chk("R1 lowest-prio queued", irr_top, 8'h50);
    send(3'd0, 8'h50, 1'b0);
    chk("R1 duplicate", irr_top, 8'h50);
    do_ack(1, 8'h50, 3'd0, 1'b1);
    chk("R8 isr_top", isr_top, 8'h50);
    chk("R8 irr_top next", irr_top, 8'h35);
    chk("R6 below in-service", deliverable, 0);
    pulse_eoi();
    chk("R9 isr_top cleared", isr_top, 0);
    chk("R6 deliverable again", deliverable, 1);
    do_ack(1, 8'h35, 3'd0, 1'b0);
    pulse_eoi();
    chk("R11 irr empty", irr_top, 0);
    chk("R11 isr empty", isr_top, 0);

    // R5 reserved mode dropped
    send(3'd3, 8'h90, 1'b1);
    chk("R5 irr_top", irr_top, 0);
    chk("R5 deliverable", deliverable, 0);

    // R3/R4 special flags and order
    @(negedge clk); int_en = 1'b0;
    send(3'd7, 8'h21, 1'b0);
    chk("R4 external masked", deliverable, 0);
    send(3'd7, 8'h22, 1'b0);
    send(3'd4, 8'h02, 1'b0);
    chk("R3 nmi unmaskable", deliverable, 1);
    send(3'd2, 8'h03, 1'b0);
    send(3'd5, 8'h04, 1'b0);
    send(3'd6, 8'h05, 1'b0);
    send(3'd4, 8'h77, 1'b0);
    send(3'd0, 8'hF0, 1'b0);
    do_ack(1, 8'h03, 3'd5, 1'b0);
    do_ack(1, 8'h02, 3'd4, 1'b0);
    do_ack(1, 8'h04, 3'd3, 1'b0);
    do_ack(1, 8'h05, 3'd2, 1'b0);
    chk("R4 ext and regular held", deliverable, 0);
    do_ack(0, 8'h00, 3'd0, 1'b0);
    @(negedge clk); int_en = 1'b1;
    do_ack(1, 8'h21, 3'd1, 1'b0);
    do_ack(1, 8'hF0, 3'd0, 1'b0);
    pulse_eoi();
    chk("R9 after F0", isr_top, 0);
    do_ack(0, 8'h00, 3'd0, 1'b0);

    // R2 trigger bit rewritten on fresh set
    send(3'd0, 8'h60, 1'b1);
    do_ack(1, 8'h60, 3'd0, 1'b1);
    pulse_eoi();
    send(3'd0, 8'h60, 1'b0);
    do_ack(1, 8'h60, 3'd0, 1'b0);
    pulse_eoi();

    repeat (2) @(negedge clk);
    chk("R7 scoreboard drained", sb_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule